// File: doc/BRIEF.md
# Load/Store Effective Offset Generator

This block sits in the address stage of a load/store path. For each memory request it forms the byte offset that the access uses. It also forms the value that the address register holds after the access.

The caller supplies four values each cycle:
- a 37-bit address register value;
- a 64-bit general register value;
- a 3-bit addressing mode;
- a 5-bit two's-complement displacement counted in data elements, together with an element-size code.

The mode picks the base offset, which is the address register, the general register, or their sum. The mode also picks whether the address register is left alone, advanced by the general register, or stepped up or down by one element. The displacement is scaled to bytes by the element size and always added to the base. All arithmetic wraps modulo 2^37.

Results are registered with one cycle of latency. A request strobe acts as the clock enable of the result registers. The address-register write-enable tells the register file whether to take the new value.

Top module: `lsag_offset_gen`

## Requirements
- R1: Mode 0 gives an offset equal to the address register plus the scaled displacement, and does not update the address register.
- R2: Mode 1 gives an offset equal to the address register plus the scaled displacement, and the new address register is the address register plus the low 37 bits of the general register.
- R3: Mode 2 gives an offset equal to the low 37 bits of the general register plus the scaled displacement; the address register value has no effect on it.
- R4: Mode 3 gives an offset equal to the address register plus the general register plus the scaled displacement, with no address register update.
- R5: Modes 4 and 5 give an offset equal to the address register plus the scaled displacement. The new address register is the old one plus (mode 4) or minus (mode 5) the element size in bytes.
- R6: Modes 6 and 7 give an offset equal to the address register plus the general register plus the scaled displacement. The new address register is the old one plus (mode 6) or minus (mode 7) the element size in bytes.
- R7: The displacement is a 5-bit two's-complement element count, multiplied by the element size in bytes before it is added. Size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes, and codes 5 to 7 also mean 16 bytes. Code 1Ah with size code 2 adds -24 bytes.
- R8: All sums wrap modulo 2^37, and bits 63:37 of the general register are ignored.
- R9: The write-enable is high after a request in modes 1, 4, 5, 6 or 7 and low otherwise. When a request does not update the register, the new address register output equals the incoming address register.
- R10: Results appear on the outputs one clock after the request. While reset is low, all outputs are zero.
- R11: A cycle without a request leaves the offset and new address register outputs unchanged and drives the write-enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronous to clk_i |
| req_i | input | 1 | Request strobe, clock enable for the result registers |
| mode_i | input | 3 | Addressing mode 0 to 7 |
| ar_i | input | 37 | Current address register value |
| gr_i | input | 64 | General register value (low 37 bits used) |
| disp_i | input | 5 | Signed displacement in elements |
| size_i | input | 3 | Element size code |
| eff_off_o | output | 37 | Effective byte offset |
| ar_next_o | output | 37 | New address register value |
| ar_we_o | output | 1 | Address register write-enable |

## Verification
The assertions check, on every cycle, the following properties:
- the write-enable tracks the mode set of the previous request;
- a request that does not update the register passes the address register through;
- the post-add of mode 1 and the element-size steps of modes 4 to 7 are correct;
- mode 0 and mode 2 with a zero displacement yield the bare base;
- idle cycles hold the results.

Only the bench's scenarios show the following:
- the scaled signed displacement for every size code, including the clamped codes and the -24 byte case;
- wrap-around at 2^37;
- the ignored upper general register bits;
- the zero outputs during reset.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  typedef enum logic [2:0] {
    AM_AR         = 3'd0,
    AM_AR_ADD_GR  = 3'd1,
    AM_GR         = 3'd2,
    AM_AR_GR      = 3'd3,
    AM_AR_INC     = 3'd4,
    AM_AR_DEC     = 3'd5,
    AM_ARGR_INC   = 3'd6,
    AM_ARGR_DEC   = 3'd7
  } addr_mode_e;

  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_ADD_GR = 2'd1,
    UPD_ADD_SZ = 2'd2,
    UPD_SUB_SZ = 2'd3
  } ar_upd_e;

  typedef struct packed {
    logic    use_ar;
    logic    use_gr;
    ar_upd_e upd;
  } mode_ctl_t;

endpackage

// File: rtl/lsag_mode_decode.sv
module lsag_mode_decode
  import lsag_pkg::*;
(
  input  addr_mode_e mode_i,
  output mode_ctl_t  ctl_o
);

  always_comb begin
    ctl_o = '{use_ar: 1'b1, use_gr: 1'b0, upd: UPD_NONE};
    unique case (mode_i)
      AM_AR:        ctl_o = '{use_ar: 1'b1, use_gr: 1'b0, upd: UPD_NONE};
      AM_AR_ADD_GR: ctl_o = '{use_ar: 1'b1, use_gr: 1'b0, upd: UPD_ADD_GR};
      AM_GR:        ctl_o = '{use_ar: 1'b0, use_gr: 1'b1, upd: UPD_NONE};
      AM_AR_GR:     ctl_o = '{use_ar: 1'b1, use_gr: 1'b1, upd: UPD_NONE};
      AM_AR_INC:    ctl_o = '{use_ar: 1'b1, use_gr: 1'b0, upd: UPD_ADD_SZ};
      AM_AR_DEC:    ctl_o = '{use_ar: 1'b1, use_gr: 1'b0, upd: UPD_SUB_SZ};
      AM_ARGR_INC:  ctl_o = '{use_ar: 1'b1, use_gr: 1'b1, upd: UPD_ADD_SZ};
      AM_ARGR_DEC:  ctl_o = '{use_ar: 1'b1, use_gr: 1'b1, upd: UPD_SUB_SZ};
      default:      ctl_o = '{use_ar: 1'b1, use_gr: 1'b0, upd: UPD_NONE};
    endcase
  end

endmodule

// File: rtl/lsag_disp_scale.sv
module lsag_disp_scale #(
  parameter int AR_W      = 37,
  parameter int DISP_W    = 5,
  parameter int SZ_W      = 3,
  parameter int MAX_SHIFT = 4
) (
  input  logic [DISP_W-1:0] disp_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic [AR_W-1:0]   disp_bytes_o,
  output logic [AR_W-1:0]   elem_bytes_o
);

  localparam int EXT_W = AR_W - DISP_W;
  localparam int NSH   = MAX_SHIFT + 1;

  logic [AR_W-1:0] disp_ext;
  logic [SZ_W-1:0] shamt;
  logic [AR_W-1:0] cand  [NSH];
  logic [AR_W-1:0] ecand [NSH];

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign shamt    = (size_i > SZ_W'(MAX_SHIFT)) ? SZ_W'(MAX_SHIFT) : size_i;

  for (genvar g = 0; g < NSH; g++) begin : g_shift
    assign cand[g]  = disp_ext << g;
    assign ecand[g] = AR_W'(1) << g;
  end

  always_comb begin
    disp_bytes_o = cand[0];
    elem_bytes_o = ecand[0];
    for (int k = 1; k < NSH; k++) begin
      if (shamt == SZ_W'(k)) begin
        disp_bytes_o = cand[k];
        elem_bytes_o = ecand[k];
      end
    end
  end

endmodule

// File: rtl/lsag_ar_update.sv
module lsag_ar_update
  import lsag_pkg::*;
#(
  parameter int AR_W = 37
) (
  input  logic [AR_W-1:0] ar_i,
  input  logic [AR_W-1:0] gr_lo_i,
  input  logic [AR_W-1:0] elem_bytes_i,
  input  ar_upd_e         upd_i,
  output logic [AR_W-1:0] ar_new_o
);

  always_comb begin
    unique case (upd_i)
      UPD_ADD_GR: ar_new_o = ar_i + gr_lo_i;
      UPD_ADD_SZ: ar_new_o = ar_i + elem_bytes_i;
      UPD_SUB_SZ: ar_new_o = ar_i - elem_bytes_i;
      default:    ar_new_o = ar_i;
    endcase
  end

endmodule

// File: rtl/lsag_offset_gen.sv
module lsag_offset_gen
  import lsag_pkg::*;
#(
  parameter int AR_W      = 37,
  parameter int GR_W      = 64,
  parameter int DISP_W    = 5,
  parameter int SZ_W      = 3,
  parameter int MAX_SHIFT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        mode_i,
  input  logic [AR_W-1:0]   ar_i,
  input  logic [GR_W-1:0]   gr_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic [AR_W-1:0]   eff_off_o,
  output logic [AR_W-1:0]   ar_next_o,
  output logic              ar_we_o
);

  mode_ctl_t       ctl;
  logic [AR_W-1:0] gr_lo;
  logic [AR_W-1:0] disp_bytes;
  logic [AR_W-1:0] elem_bytes;
  logic [AR_W-1:0] ar_new;
  logic [AR_W-1:0] base;
  logic [AR_W-1:0] eff_off_d;
  logic [AR_W-1:0] ar_next_d;
  logic            ar_we_d;
  logic            unused_gr_hi;

  assign gr_lo        = gr_i[AR_W-1:0];
  assign unused_gr_hi = ^gr_i[GR_W-1:AR_W];

  lsag_mode_decode u_dec (
    .mode_i (addr_mode_e'(mode_i)),
    .ctl_o  (ctl)
  );

  lsag_disp_scale #(
    .AR_W      (AR_W),
    .DISP_W    (DISP_W),
    .SZ_W      (SZ_W),
    .MAX_SHIFT (MAX_SHIFT)
  ) u_scale (
    .disp_i       (disp_i),
    .size_i       (size_i),
    .disp_bytes_o (disp_bytes),
    .elem_bytes_o (elem_bytes)
  );

  lsag_ar_update #(
    .AR_W (AR_W)
  ) u_upd (
    .ar_i         (ar_i),
    .gr_lo_i      (gr_lo),
    .elem_bytes_i (elem_bytes),
    .upd_i        (ctl.upd),
    .ar_new_o     (ar_new)
  );

  // Next-state logic
  always_comb begin
    base      = (ctl.use_ar ? ar_i : '0) + (ctl.use_gr ? gr_lo : '0);
    eff_off_d = base + disp_bytes;
    ar_we_d   = req_i && (ctl.upd != UPD_NONE);
    ar_next_d = ar_new;
  end

  // Result registers, clock-enabled by the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_off_o <= '0;
      ar_next_o <= '0;
    end else if (req_i) begin
      eff_off_o <= eff_off_d;
      ar_next_o <= ar_next_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ar_we_o <= 1'b0;
    else         ar_we_o <= ar_we_d;
  end

endmodule

// File: rtl/lsag_offset_gen_chk.sv
module lsag_offset_gen_chk #(
  parameter int AR_W      = 37,
  parameter int GR_W      = 64,
  parameter int DISP_W    = 5,
  parameter int SZ_W      = 3,
  parameter int MAX_SHIFT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [2:0]        mode_i,
  input logic [AR_W-1:0]   ar_i,
  input logic [GR_W-1:0]   gr_i,
  input logic [DISP_W-1:0] disp_i,
  input logic [SZ_W-1:0]   size_i,
  input logic [AR_W-1:0]   eff_off_o,
  input logic [AR_W-1:0]   ar_next_o,
  input logic              ar_we_o
);

  logic            primed;
  logic [AR_W-1:0] step_bytes;
  logic            upd_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  always_comb begin
    step_bytes = AR_W'(1) << MAX_SHIFT;
    for (int k = 0; k < MAX_SHIFT; k++)
      if (size_i == SZ_W'(k)) step_bytes = AR_W'(1) << k;
    upd_mode = (mode_i == 3'd1) || (mode_i >= 3'd4);
  end

  AST_WE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |-> (ar_we_o == $past(req_i && upd_mode))); // R9

  AST_AR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(req_i) && !ar_we_o) |-> (ar_next_o == $past(ar_i))); // R9

  AST_MODE1_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(req_i && mode_i == 3'd1)) |->
      (ar_next_o == $past(ar_i) + $past(gr_i[AR_W-1:0]))); // R2

  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(req_i && (mode_i == 3'd4 || mode_i == 3'd6))) |->
      (ar_next_o == $past(ar_i) + $past(step_bytes))); // R5

  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(req_i && (mode_i == 3'd5 || mode_i == 3'd7))) |->
      (ar_next_o == $past(ar_i) - $past(step_bytes))); // R6

  AST_MODE0_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(req_i && mode_i == 3'd0 && disp_i == '0)) |->
      (eff_off_o == $past(ar_i))); // R1

  AST_MODE2_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(req_i && mode_i == 3'd2 && disp_i == '0)) |->
      (eff_off_o == $past(gr_i[AR_W-1:0]))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(!req_i)) |->
      ($stable(eff_off_o) && $stable(ar_next_o) && !ar_we_o)); // R11

endmodule

bind lsag_offset_gen lsag_offset_gen_chk #(
  .AR_W      (AR_W),
  .GR_W      (GR_W),
  .DISP_W    (DISP_W),
  .SZ_W      (SZ_W),
  .MAX_SHIFT (MAX_SHIFT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .mode_i    (mode_i),
  .ar_i      (ar_i),
  .gr_i      (gr_i),
  .disp_i    (disp_i),
  .size_i    (size_i),
  .eff_off_o (eff_off_o),
  .ar_next_o (ar_next_o),
  .ar_we_o   (ar_we_o)
);

// File: tb/lsag_offset_gen_test.sv
module lsag_offset_gen_test;

  localparam int AR_W = 37;
  localparam int GR_W = 64;
  localparam logic [AR_W-1:0] AMASK = '1;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            req_i;
  logic [2:0]      mode_i;
  logic [AR_W-1:0] ar_i;
  logic [GR_W-1:0] gr_i;
  logic [4:0]      disp_i;
  logic [2:0]      size_i;
  logic [AR_W-1:0] eff_off_o;
  logic [AR_W-1:0] ar_next_o;
  logic            ar_we_o;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model state
  logic [AR_W-1:0] m_eo = '0;
  logic [AR_W-1:0] m_ar = '0;
  logic            m_we = 1'b0;

  always #10 clk_i = ~clk_i;

  lsag_offset_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .mode_i(mode_i),
    .ar_i(ar_i), .gr_i(gr_i), .disp_i(disp_i), .size_i(size_i),
    .eff_off_o(eff_off_o), .ar_next_o(ar_next_o), .ar_we_o(ar_we_o)
  );

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [AR_W-1:0] act,
                       input logic [AR_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural model: applied at the clock edge that captures the inputs
  task automatic model_step();
    longint eb, sd, base, eo, arn;
    int sh;
    if (!req_i) begin
      m_we = 1'b0;
      return;
    end
    sh   = (size_i > 3'd4) ? 4 : int'(size_i);
    eb   = longint'(1) << sh;
    sd   = longint'($signed(disp_i)) * eb;
    base = 0;
    if (mode_i != 3'd2) base += longint'(ar_i);
    if (mode_i == 3'd2 || mode_i == 3'd3 || mode_i >= 3'd6)
      base += longint'(gr_i[AR_W-1:0]);
    eo  = base + sd;
    arn = longint'(ar_i);
    case (mode_i)
      3'd1: arn += longint'(gr_i[AR_W-1:0]);
      3'd4, 3'd6: arn += eb;
      3'd5, 3'd7: arn -= eb;
      default: ;
    endcase
    m_eo = AR_W'(eo) & AMASK;
    m_ar = AR_W'(arn) & AMASK;
    m_we = (mode_i == 3'd1) || (mode_i >= 3'd4);
  endtask

  // Called at a negative edge: drive, clock, compare.
  task automatic step(input logic rq, input logic [2:0] m, input logic [AR_W-1:0] a,
                      input logic [GR_W-1:0] g, input logic [4:0] d,
                      input logic [2:0] s, input string tag);
    req_i = rq; mode_i = m; ar_i = a; gr_i = g; disp_i = d; size_i = s;
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    check({tag, " offset"},  eff_off_o, m_eo);
    check({tag, " ar_next"}, ar_next_o, m_ar);
    check("R9 write-enable", AR_W'(ar_we_o), AR_W'(m_we));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req_i = 1'b0; mode_i = '0; ar_i = '0; gr_i = '0;
    disp_i = '0; size_i = '0;
    repeat (3) @(negedge clk_i);
    // R10: outputs are zero while reset is low
    check("R10 reset offset", eff_off_o, '0);
    check("R10 reset ar_next", ar_next_o, '0);
    check("R10 reset we", AR_W'(ar_we_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // One directed request per mode
    step(1, 3'd0, 37'h0_0000_1000, 64'h0, 5'd3, 3'd3, "R1");
    step(1, 3'd1, 37'h0_0000_2000, 64'h40, 5'd1, 3'd0, "R2");
    step(1, 3'd2, 37'h1_2345_6789, 64'h0_0000_0500, 5'd0, 3'd1, "R3");
    step(1, 3'd3, 37'h0_0000_0100, 64'h0_0000_0020, 5'd2, 3'd2, "R4");
    step(1, 3'd4, 37'h0_0000_0800, 64'h0, 5'd0, 3'd3, "R5");
    step(1, 3'd5, 37'h0_0000_0800, 64'h0, 5'd31, 3'd1, "R5");
    step(1, 3'd6, 37'h0_0000_1000, 64'h0_0000_0010, 5'd1, 3'd4, "R6");
    step(1, 3'd7, 37'h0_0000_1000, 64'h0_0000_0010, 5'd16, 3'd2, "R6");
    // R7: field 1Ah with 4-byte elements gives -24 bytes
    step(1, 3'd0, 37'h0_0000_0100, 64'h0, 5'h1A, 3'd2, "R7");
    check("R7 -24 direct", eff_off_o, 37'h0_0000_00E8);
    // R7: clamped size codes act as 16 bytes
    step(1, 3'd4, 37'h0_0000_0000, 64'h0, 5'd2, 3'd6, "R7");
    check("R7 clamp step", ar_next_o, 37'h0_0000_0010);
    check("R7 clamp disp", eff_off_o, 37'h0_0000_0020);
    // R8: wrap-around and ignored upper general register bits
    step(1, 3'd4, 37'h1F_FFFF_FFFF, 64'h0, 5'd0, 3'd0, "R8");
    check("R8 wrap", ar_next_o, 37'h0);
    step(1, 3'd2, 37'h0, 64'hFFFF_FFE0_0000_0007, 5'd0, 3'd0, "R8");
    check("R8 upper gr ignored", eff_off_o, 37'h0_0000_0007);
    // R3: address register has no effect in mode 2
    step(1, 3'd2, 37'h1F_0000_0000, 64'h0_0000_0007, 5'd0, 3'd0, "R3");
    check("R3 ar ignored", eff_off_o, 37'h0_0000_0007);
    // R11: idle cycles hold the results and drop the write-enable
    step(1, 3'd1, 37'h0_0000_0400, 64'h4, 5'd0, 3'd0, "R2");
    step(0, 3'd4, 37'h1_1111_1111, 64'h9, 5'd7, 3'd1, "R11");
    check("R11 hold offset", eff_off_o, 37'h0_0000_0400);
    check("R11 hold ar", ar_next_o, 37'h0_0000_0404);
    // R9: non-updating mode passes the address register through
    step(1, 3'd3, 37'h0_0ABC_0000, 64'h1, 5'd0, 3'd0, "R9");
    check("R9 pass-through", ar_next_o, 37'h0_0ABC_0000);

    // Pseudo-random traffic compared to the model every cycle
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 7) != 0), m,
           {5'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)},
           5'($urandom), 3'($urandom_range(0, 7)), mode_tag(m));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule